// File: doc/BRIEF.md
# LIN Slave Field Receiver

This block receives single-byte fields of a LIN frame (identifier, data bytes, checksum) from the bus receive line. It does not run freely. It is armed only when an external break/sync detector signals a valid sync pattern. The detector also supplies the measured bit-period count. Once armed, the block waits for a start edge, shifts in eight data bits least significant bit first, and checks the stop bit. It then hands the byte to a one-entry buffer that software drains.

A good byte leaves the receiver armed for the next field, so consecutive data bytes need no software action. A low stop bit means either a baud mismatch or a new break. In that case the block disarms itself until the next sync. Software ends reception on purpose with a one-cycle stop strobe. A sync that arrives during a byte throws that byte away and re-arms the receiver with the new timing.

Top module: `lin_field_rx`

## Requirements
- R1: A field is one low start bit, eight data bits least significant bit first, and one high stop bit. A good field places its eight data bits on `rx_data` with the first data bit in bit 0.
- R2: One bit period is `baud+1` clock cycles. `baud` is the value on `sync_baud` captured on the latest `sync_stb`. A new sync replaces it.
- R3: On `sync_stb` the block does four things: it loads the baud value, sets `rx_en` to 1, sets `rx_act` to 0, and sets `sync_flag` to 1. `sync_flag` stays 1 until a cycle with `sync_clr` high.
- R4: A `sync_stb` during a byte discards the partial byte and returns the receiver to enabled-but-idle. No buffer write and no overflow result from the discarded byte.
- R5: While `rx_en` is 1 and `rx_act` is 0, a falling edge on the synchronized receive line sets `rx_act` to 1. While `rx_en` is 0, falling edges are ignored.
- R6: Each data bit is sampled in the middle of its bit period. `rx_act` returns to 0 in the middle of the stop bit. A high stop bit with an empty buffer writes the byte to `rx_data` and sets `rx_full`.
- R7: A high stop bit while `rx_full` is 1 drops the byte, leaves `rx_data` unchanged and sets `rx_ovf`. `rx_ovf` stays 1 until a cycle with `ovf_clr` high.
- R8: A low stop bit writes nothing to the buffer and clears `rx_en`. Later fields are ignored until the next `sync_stb`.
- R9: After a good byte, `rx_en` stays 1 and the next field is received without any software action.
- R10: `stop_stb` clears `rx_en` and `rx_act` and abandons any byte in progress. If it arrives in the same cycle as `sync_stb`, the stop wins for these two bits.
- R11: `rd_ack` clears `rx_full`.
- R12: After reset, `rx_en`, `rx_act`, `rx_full`, `rx_ovf` and `sync_flag` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Bus receive line, idle high |
| sync_stb | input | 1 | One-cycle pulse: valid break/sync detected |
| sync_baud | input | BAUD_W | Bit period minus one, in clock cycles, captured with `sync_stb` |
| stop_stb | input | 1 | One-cycle software stop-receive strobe |
| rd_ack | input | 1 | Buffer read acknowledge, clears `rx_full` |
| ovf_clr | input | 1 | Write-one clear of `rx_ovf` |
| sync_clr | input | 1 | Write-one clear of `sync_flag` |
| rx_en | output | 1 | Receiver armed |
| rx_act | output | 1 | Byte reception in progress |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | A byte was dropped because the buffer was full |
| sync_flag | output | 1 | Sync detected, held until cleared |

## Verification
The bench sends a field while the receiver is still disarmed. A design that reacts to edges without checking the enable bit would go active and fill the buffer. It sends a second byte into a full buffer. A design that overwrites the buffer would replace the first byte instead of raising overflow. It sends a field with a low stop bit and then a good one. A design that did not disarm on the bad stop would accept the later byte. It also changes the baud between syncs and cuts a byte short with a sync or a stop strobe. A design that kept the old timing, or kept the partial byte, would deliver a corrupted value or leave the active bit set.

// File: rtl/lin_field_rx.sv
module lin_field_rx #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              sync_stb,
  input  logic [BAUD_W-1:0] sync_baud,
  input  logic              stop_stb,
  input  logic              rd_ack,
  input  logic              ovf_clr,
  input  logic              sync_clr,
  output logic              rx_en,
  output logic              rx_act,
  output logic [7:0]        rx_data,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              sync_flag
);
  localparam int          IDX_W    = 4;
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(8);
  localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(9);

  logic [2:0]        line_sr;
  logic [BAUD_W-1:0] baud_q;
  logic [BAUD_W-1:0] tmr;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        shreg;

  wire smp  = line_sr[1];
  wire fall = line_sr[2] & ~line_sr[1];
  wire tick = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_sr <= 3'b111;
    else        line_sr <= {line_sr[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q    <= '0;
      tmr       <= '0;
      idx       <= '0;
      shreg     <= '0;
      rx_en     <= 1'b0;
      rx_act    <= 1'b0;
      rx_data   <= '0;
      rx_full   <= 1'b0;
      rx_ovf    <= 1'b0;
      sync_flag <= 1'b0;
    end else begin
      if (rd_ack)   rx_full   <= 1'b0;
      if (ovf_clr)  rx_ovf    <= 1'b0;
      if (sync_clr) sync_flag <= 1'b0;

      if (sync_stb) begin
        baud_q    <= sync_baud;
        rx_en     <= 1'b1;
        rx_act    <= 1'b0;
        sync_flag <= 1'b1;
      end else if (rx_act) begin
        if (!tick) begin
          tmr <= tmr - 1'b1;
        end else begin
          tmr <= baud_q;
          idx <= idx + 1'b1;
          if (idx != '0 && idx <= LAST_DATA)
            shreg <= {smp, shreg[7:1]};
          if (idx == STOP_IDX) begin
            rx_act <= 1'b0;
            if (!smp)         rx_en  <= 1'b0;
            else if (rx_full) rx_ovf <= 1'b1;
            else begin
              rx_data <= shreg;
              rx_full <= 1'b1;
            end
          end
        end
      end else if (rx_en && fall) begin
        rx_act <= 1'b1;
        tmr    <= baud_q >> 1;
        idx    <= '0;
      end

      if (stop_stb) begin
        rx_en  <= 1'b0;
        rx_act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lin_field_rx_chk.sv
module lin_field_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_stb,
  input logic       stop_stb,
  input logic       rd_ack,
  input logic       ovf_clr,
  input logic       sync_clr,
  input logic       rx_en,
  input logic       rx_act,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       rx_ovf,
  input logic       sync_flag
);
  p_act_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |-> rx_en);

  p_act_rise_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_act) |-> $past(rx_en));

  p_sync_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_stb && !stop_stb) |=> (rx_en && !rx_act && sync_flag));

  p_sync_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_flag && !sync_clr) |=> sync_flag);

  p_stop_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (!rx_en && !rx_act));

  p_full_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_ack) |=> (rx_full && $stable(rx_data)));

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clr) |=> rx_ovf);

  p_ack_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rx_full);
endmodule

bind lin_field_rx lin_field_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .stop_stb(stop_stb),
  .rd_ack(rd_ack), .ovf_clr(ovf_clr), .sync_clr(sync_clr),
  .rx_en(rx_en), .rx_act(rx_act), .rx_data(rx_data), .rx_full(rx_full),
  .rx_ovf(rx_ovf), .sync_flag(sync_flag)
);

// File: tb/test_lin_field_rx.sv
`timescale 1ns/1ps
module test_lin_field_rx;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          sync_stb = 1'b0;
  logic [BW-1:0] sync_baud = '0;
  logic          stop_stb = 1'b0;
  logic          rd_ack = 1'b0;
  logic          ovf_clr = 1'b0;
  logic          sync_clr = 1'b0;
  logic          rx_en, rx_act, rx_full, rx_ovf, sync_flag;
  logic [7:0]    rx_data;

  int n_chk = 0;
  int n_bad = 0;
  int per = 16;

  always #4 clk = ~clk;

  lin_field_rx #(.BAUD_W(BW)) i_lin_field_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .sync_stb(sync_stb),
    .sync_baud(sync_baud), .stop_stb(stop_stb), .rd_ack(rd_ack),
    .ovf_clr(ovf_clr), .sync_clr(sync_clr), .rx_en(rx_en), .rx_act(rx_act),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf), .sync_flag(sync_flag)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic do_sync(input int baud);
    @(negedge clk);
    sync_baud = BW'(baud);
    sync_stb  = 1'b1;
    @(negedge clk) sync_stb = 1'b0;
    per = baud + 1;
  endtask

  task automatic send_bits(input logic [7:0] b, input logic stopb, input int nbits);
    logic [9:0] fr;
    fr = {stopb, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      rxd = fr[i];
      repeat (per) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopb);
    send_bits(b, stopb, 10);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 en", rx_en, 0);
    chk("R12 act", rx_act, 0);
    chk("R12 full", rx_full, 0);
    chk("R12 ovf", rx_ovf, 0);
    chk("R12 sync_flag", sync_flag, 0);
    chk("R12 data", rx_data, 0);
  endtask

  task automatic t_disabled;
    send_bits(8'h66, 1'b1, 4);
    chk("R5 no act while disabled", rx_act, 0);
    send_bits(8'h66, 1'b1, 0);
    rxd = 1'b1;
    repeat (7 * per) @(negedge clk);
    chk("R5 no write while disabled", rx_full, 0);
  endtask

  task automatic t_sync;
    do_sync(15);
    chk("R3 en", rx_en, 1);
    chk("R3 act", rx_act, 0);
    chk("R3 flag", sync_flag, 1);
    repeat (5) @(negedge clk);
    chk("R3 flag held", sync_flag, 1);
    pulse(sync_clr);
    chk("R3 flag cleared", sync_flag, 0);
  endtask

  task automatic t_good;
    send_frame(8'hA5, 1'b1);
    chk("R1 data", rx_data, 8'hA5);
    chk("R6 full", rx_full, 1);
    chk("R6 act done", rx_act, 0);
    chk("R9 still enabled", rx_en, 1);
  endtask

  task automatic t_overflow;
    send_frame(8'h5A, 1'b1);
    chk("R7 ovf set", rx_ovf, 1);
    chk("R7 data kept", rx_data, 8'hA5);
    chk("R7 full kept", rx_full, 1);
    repeat (3) @(negedge clk);
    chk("R7 ovf held", rx_ovf, 1);
    pulse(ovf_clr);
    chk("R7 ovf cleared", rx_ovf, 0);
    pulse(rd_ack);
    chk("R11 full cleared", rx_full, 0);
  endtask

  task automatic t_next;
    send_frame(8'h17, 1'b1);
    chk("R9 next byte", rx_data, 8'h17);
    chk("R9 full", rx_full, 1);
    pulse(rd_ack);
  endtask

  task automatic t_rebaud;
    do_sync(9);
    send_frame(8'h3C, 1'b1);
    chk("R2 new period data", rx_data, 8'h3C);
    chk("R2 full", rx_full, 1);
    pulse(rd_ack);
  endtask

  task automatic t_sync_abort;
    send_bits(8'hFF, 1'b1, 4);
    chk("R5 active mid byte", rx_act, 1);
    do_sync(9);
    chk("R4 inactive after sync", rx_act, 0);
    chk("R4 enabled after sync", rx_en, 1);
    rxd = 1'b1;
    repeat (2 * per) @(negedge clk);
    chk("R4 partial not stored", rx_full, 0);
    send_frame(8'hC3, 1'b1);
    chk("R4 fresh byte", rx_data, 8'hC3);
    chk("R4 no ovf", rx_ovf, 0);
    pulse(rd_ack);
  endtask

  task automatic t_bad_stop;
    send_frame(8'h81, 1'b0);
    chk("R8 disarmed", rx_en, 0);
    chk("R8 no write", rx_full, 0);
    chk("R8 data kept", rx_data, 8'hC3);
    send_frame(8'h7E, 1'b1);
    chk("R8 later byte ignored", rx_full, 0);
    chk("R8 stays idle", rx_act, 0);
  endtask

  task automatic t_stop;
    do_sync(9);
    send_bits(8'h00, 1'b1, 5);
    chk("R10 active before stop", rx_act, 1);
    pulse(stop_stb);
    chk("R10 en cleared", rx_en, 0);
    chk("R10 act cleared", rx_act, 0);
    rxd = 1'b1;
    repeat (2 * per) @(negedge clk);
    send_frame(8'h55, 1'b1);
    chk("R10 byte ignored", rx_full, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_sync();
    t_good();
    t_overflow();
    t_next();
    t_rebaud();
    t_sync_abort();
    t_bad_stop();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule